// File: doc/BRIEF.md
# Selectable Gradient Edge Detector

This block turns a stream of 8-bit grayscale pixels into a stream of binary edge decisions. Pixels arrive in raster order, at most one per clock, each marked by a valid flag; gaps in the valid flag may appear anywhere. Two row stores and a small shift array hold a neighbourhood of recent pixels. From that neighbourhood the block forms a horizontal and a vertical gradient with one of three operators: a 2x2 diagonal difference, a 3x3 operator with equal weights, or a 3x3 operator whose middle taps count double. The middle taps are doubled by a one-bit left shift, so no multiplier is used.

The two components are folded into a magnitude |Gx| + |Gy|, which is compared with a threshold. The result is one edge bit for every accepted pixel. Operator choice and threshold are taken once per frame, so a host can change them at any time without tearing a frame. For every input pixel the edge bit describes the neighbourhood whose newest (bottom-right) pixel is that input pixel. Neighbourhoods that would need pixels above the first row or left of the first column give 0. Output valid follows input valid after a fixed delay.

Top module: `edge_detect_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid and out_edge are 0.
- R2: out_valid equals in_valid delayed by exactly 3 clock cycles, in every mode and with any pattern of stalls. Stall cycles do not move or alter the neighbourhood.
- R3: With op_sel = 2'b00 (diagonal), for the input at row r, column c, Gx = P(r-1,c-1) - P(r,c) and Gy = P(r-1,c) - P(r,c-1).
- R4: With op_sel = 2'b01 (equal weights), and also with the spare code 2'b11, for the 3x3 neighbourhood of rows r-2..r and columns c-2..c, Gx is the sum of the right column minus the sum of the left column, and Gy is the sum of the bottom row minus the sum of the top row.
- R5: With op_sel = 2'b10 (centre weighted), the sums are the same as in R4, except that the middle tap of each outer column (for Gx) and of each outer row (for Gy) counts twice.
- R6: The magnitude |Gx| + |Gy| is computed without overflow for every pixel value, up to 4*255 per component. out_edge is 1 only when the magnitude is strictly greater than edge_thr; equal gives 0.
- R7: out_edge is 0, with out_valid still 1, when r < 1 or c < 1 in the diagonal mode, and when r < 2 or c < 2 in the 3x3 modes.
- R8: op_sel and edge_thr are captured only with the first valid pixel of a frame. Changes at other times do not affect the frame in progress.
- R9: A frame begins with the first valid pixel after reset, after a frame_start pulse (this pixel may carry the pulse itself), or after the last pixel (row ROWS-1, column LINE_W-1) of the previous frame. A frame_start pulse part-way through a frame restarts at row 0, column 0.
- R10: The column position wraps after LINE_W valid pixels, with LINE_W a parameter. Each pixel therefore lines up with the pixels directly above it in the neighbourhood.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse: the next valid pixel is row 0, column 0 |
| in_valid | input | 1 | in_pix holds a pixel this cycle |
| in_pix | input | PIX_W | Grayscale pixel |
| op_sel | input | 2 | Operator select: 00 diagonal, 01 equal weight, 10 centre weighted, 11 equal weight |
| edge_thr | input | THR_W | Magnitude threshold |
| out_valid | output | 1 | out_edge holds a result |
| out_edge | output | 1 | 1 when the neighbourhood is an edge |

## Verification
The hardest condition to reach from the ports is a change of operator or threshold while a frame is in flight, with stalls falling just as the frame ends and the next one begins. The last pixels of one frame are then still in the pipeline when the settings for the next frame are captured. The stimulus puts random stalls between pixels, changes op_sel and edge_thr on every cycle of one frame, runs frames back to back with no pulse, and aborts one frame halfway with a pulse. A column-step image with the threshold set exactly at, and one below, the known magnitude of 1020 covers the strict comparison.

// File: rtl/edge_pkg.sv
// Package: shared operator-select encoding for the edge detector.
// Assumes: a two-bit select at the block edge.
package edge_pkg;
    typedef enum logic [1:0] {
        OP_DIAG = 2'b00,   // 2x2 diagonal differences
        OP_UNIF = 2'b01,   // 3x3, all taps weight 1
        OP_CWT  = 2'b10,   // 3x3, middle taps weight 2
        OP_SPARE = 2'b11   // spare code, treated as OP_UNIF
    } op_mode_e;
endpackage

// File: rtl/edge_window.sv
// Module: edge_window
// Tracks the raster position, keeps the two previous rows in row stores,
// shifts a 3x3 neighbourhood whose newest pixel is the current input, and
// captures operator and threshold with the first pixel of each frame.
// Assumes: LINE_W >= 3 and ROWS >= 3; stalls (in_valid low) freeze all state.
module edge_window
    import edge_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 256,
    parameter int ROWS   = 256,
    parameter int THR_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  op_mode_e         mode_in,
    input  logic [THR_W-1:0] thr_in,
    output logic [PIX_W-1:0] win [3][3],
    output logic             v1,
    output logic             b1,
    output op_mode_e         mode_q,
    output logic [THR_W-1:0] thr_q
);
    localparam int COL_W = $clog2(LINE_W);
    localparam int ROW_W = $clog2(ROWS);
    localparam int NLB   = 2;

    logic             pending;
    logic             start;
    logic [COL_W-1:0] col, cur_col;
    logic [ROW_W-1:0] row, cur_row;
    logic             last_col, last_px;
    op_mode_e         eff_mode;
    logic [1:0]       margin;
    logic [PIX_W-1:0] lb_q [NLB];

    // Position of the incoming pixel; a new frame starts at the origin.
    always_comb begin
        start    = pending | frame_start;
        cur_col  = start ? '0 : col;
        cur_row  = start ? '0 : row;
        last_col = (cur_col == COL_W'(LINE_W - 1));
        last_px  = last_col && (cur_row == ROW_W'(ROWS - 1));
        eff_mode = start ? mode_in : mode_q;
        margin   = (eff_mode == OP_DIAG) ? 2'd1 : 2'd2;
    end

    // Row stores: store 0 holds the previous row, store k the row k+1 above.
    for (genvar k = 0; k < NLB; k++) begin : g_lb
        logic [PIX_W-1:0] mem [LINE_W];
        logic [PIX_W-1:0] wr_d;
        if (k == 0) begin : g_head
            assign wr_d = in_pix;
        end else begin : g_chain
            assign wr_d = lb_q[k-1];
        end
        assign lb_q[k] = mem[cur_col];
        // Read-before-write column update on each accepted pixel.
        always_ff @(posedge clk) begin
            if (in_valid) mem[cur_col] <= wr_d;
        end
    end

    // Raster counters and the pending-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col     <= '0;
            row     <= '0;
            pending <= 1'b1;
        end else if (in_valid) begin
            pending <= last_px;
            if (last_px) begin
                col <= '0;
                row <= '0;
            end else if (last_col) begin
                col <= '0;
                row <= cur_row + 1'b1;
            end else begin
                col <= cur_col + 1'b1;
                row <= cur_row;
            end
        end else if (frame_start) begin
            pending <= 1'b1;
        end
    end

    // Per-frame capture of operator and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_DIAG;
            thr_q  <= '0;
        end else if (in_valid && start) begin
            mode_q <= mode_in;
            thr_q  <= thr_in;
        end
    end

    // Neighbourhood shift: left columns age, right column loads new taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    win[i][j] <= '0;
        end else if (in_valid) begin
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 2; j++)
                    win[i][j] <= win[i][j+1];
            win[0][2] <= lb_q[1];
            win[1][2] <= lb_q[0];
            win[2][2] <= in_pix;
        end
    end

    // Valid and border tag travel with the neighbourhood.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            b1 <= 1'b0;
        end else begin
            v1 <= in_valid;
            b1 <= (int'(cur_row) < int'(margin)) || (int'(cur_col) < int'(margin));
        end
    end

    // R8: settings move only when a frame begins.
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && start) |=> ($stable(mode_q) && $stable(thr_q)));

    // R10: position counters stay inside the frame.
    a_r10_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col) < LINE_W) && (int'(row) < ROWS));
endmodule

// File: rtl/edge_grad.sv
// Module: edge_grad
// Forms the two gradient components for the selected operator from the
// 3x3 neighbourhood and registers them with valid, border tag and threshold.
// Assumes: GW >= PIX_W + 3 so that 4*max pixel fits as a signed value.
module edge_grad
    import edge_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int GW    = 11,
    parameter int THR_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIX_W-1:0]     win [3][3],
    input  logic                 v1,
    input  logic                 b1,
    input  op_mode_e             mode,
    input  logic [THR_W-1:0]     thr,
    output logic signed [GW-1:0] gx,
    output logic signed [GW-1:0] gy,
    output logic                 v2,
    output logic                 b2,
    output logic [THR_W-1:0]     thr2
);
    localparam int PAD = GW - PIX_W;
    localparam logic signed [GW-1:0] GLIM = GW'(4 * ((1 << PIX_W) - 1));

    // Widen a tap to signed, optionally doubled by a one-bit left shift.
    function automatic logic signed [GW-1:0] tap(input logic [PIX_W-1:0] p,
                                                 input logic dbl);
        return dbl ? $signed({{(PAD-1){1'b0}}, p, 1'b0})
                   : $signed({{PAD{1'b0}}, p});
    endfunction

    logic                 cw;
    logic signed [GW-1:0] xp, xn, yp, yn, gx_c, gy_c;

    // Operator selection; the 2x2 uses the bottom-right quad of the window.
    always_comb begin
        cw = (mode == OP_CWT);
        xp = tap(win[0][2], 1'b0) + tap(win[1][2], cw) + tap(win[2][2], 1'b0);
        xn = tap(win[0][0], 1'b0) + tap(win[1][0], cw) + tap(win[2][0], 1'b0);
        yp = tap(win[2][0], 1'b0) + tap(win[2][1], cw) + tap(win[2][2], 1'b0);
        yn = tap(win[0][0], 1'b0) + tap(win[0][1], cw) + tap(win[0][2], 1'b0);
        if (mode == OP_DIAG) begin
            gx_c = tap(win[1][1], 1'b0) - tap(win[2][2], 1'b0);
            gy_c = tap(win[1][2], 1'b0) - tap(win[2][1], 1'b0);
        end else begin
            gx_c = xp - xn;
            gy_c = yp - yn;
        end
    end

    // Pipeline register for the components and their side-band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gx   <= '0;
            gy   <= '0;
            v2   <= 1'b0;
            b2   <= 1'b0;
            thr2 <= '0;
        end else begin
            gx   <= gx_c;
            gy   <= gy_c;
            v2   <= v1;
            b2   <= b1;
            thr2 <= thr;
        end
    end

    // R6: components stay within +/- 4*max pixel, so no wrap occurred.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> (gx <= GLIM && gx >= -GLIM && gy <= GLIM && gy >= -GLIM));
endmodule

// File: rtl/edge_decide.sv
// Module: edge_decide
// Folds the components into |Gx| + |Gy|, compares against the frame's
// threshold and registers the edge bit with its valid flag.
// Assumes: |Gx| + |Gy| fits in GW unsigned bits (guaranteed for GW = PIX_W+3).
module edge_decide #(
    parameter int GW    = 11,
    parameter int THR_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [GW-1:0] gx,
    input  logic signed [GW-1:0] gy,
    input  logic                 v2,
    input  logic                 b2,
    input  logic [THR_W-1:0]     thr2,
    output logic                 out_valid,
    output logic                 out_edge
);
    logic [GW-1:0] ax, ay, mag;

    // Absolute values and their sum.
    always_comb begin
        ax  = gx[GW-1] ? GW'(-gx) : GW'(gx);
        ay  = gy[GW-1] ? GW'(-gy) : GW'(gy);
        mag = ax + ay;
    end

    // Strict threshold test, masked on border neighbourhoods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_edge  <= 1'b0;
        end else begin
            out_valid <= v2;
            out_edge  <= v2 && !b2 && (int'(mag) > int'(thr2));
        end
    end

    // R2: output valid follows the stage valid by one register.
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(v2));

    // R7: a border-tagged neighbourhood never yields an edge.
    a_r7_border_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(v2 && b2) |-> !out_edge);

    // R1: no edge bit without its valid flag.
    a_r1_edge_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_edge);
endmodule

// File: rtl/edge_detect_top.sv
// Module: edge_detect_top
// Streaming edge detector: neighbourhood builder, gradient stage and
// threshold stage in a fixed three-cycle pipeline.
// Assumes: raster-order pixels, LINE_W >= 3, ROWS >= 3.
module edge_detect_top
    import edge_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 256,
    parameter int ROWS   = 256,
    parameter int THR_W  = PIX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [1:0]       op_sel,
    input  logic [THR_W-1:0] edge_thr,
    output logic             out_valid,
    output logic             out_edge
);
    localparam int GW = PIX_W + 3;

    logic [PIX_W-1:0]     win [3][3];
    logic                 v1, b1, v2, b2;
    op_mode_e             mode_q;
    logic [THR_W-1:0]     thr_q, thr2;
    logic signed [GW-1:0] gx, gy;

    edge_window #(.PIX_W(PIX_W), .LINE_W(LINE_W), .ROWS(ROWS), .THR_W(THR_W)) u_win (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .in_pix(in_pix), .mode_in(op_mode_e'(op_sel)), .thr_in(edge_thr),
        .win(win), .v1(v1), .b1(b1), .mode_q(mode_q), .thr_q(thr_q)
    );

    edge_grad #(.PIX_W(PIX_W), .GW(GW), .THR_W(THR_W)) u_grad (
        .clk(clk), .rst_n(rst_n), .win(win), .v1(v1), .b1(b1), .mode(mode_q),
        .thr(thr_q), .gx(gx), .gy(gy), .v2(v2), .b2(b2), .thr2(thr2)
    );

    edge_decide #(.GW(GW), .THR_W(THR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .gx(gx), .gy(gy), .v2(v2), .b2(b2),
        .thr2(thr2), .out_valid(out_valid), .out_edge(out_edge)
    );
endmodule

// File: tb/sim_edge_detect_top.sv
module sim_edge_detect_top;
    localparam int LW = 12;
    localparam int RW = 7;

    logic        clk = 1'b0;
    logic        rst_n, frame_start, in_valid, out_valid, out_edge;
    logic [7:0]  in_pix;
    logic [1:0]  op_sel;
    logic [10:0] edge_thr;

    always #2 clk = ~clk;

    edge_detect_top #(.PIX_W(8), .LINE_W(LW), .ROWS(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .in_pix(in_pix), .op_sel(op_sel), .edge_thr(edge_thr),
        .out_valid(out_valid), .out_edge(out_edge)
    );

    int total = 0, bad = 0;
    bit done = 0;
    int img [RW][LW];
    int mr = 0, mc = 0, ms = 0, mt = 0;
    bit pend = 1;
    bit    hv [3];
    bit    he [3];
    string ht [3];

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pixval(int pat, int r, int c);
        case (pat)
            1: return (c >= LW/2) ? 255 : 0;
            2: return ((r + c) % 2) ? 255 : 0;
            3: return (r >= RW/2) ? 200 : 10;
            4: return 77;
            default: return $urandom % 256;
        endcase
    endfunction

    // Magnitude of the neighbourhood whose newest pixel is (r,c).
    function automatic int mag_of(int r, int c, int md);
        int gx, gy, k;
        if (md == 0) begin
            gx = img[r-1][c-1] - img[r][c];
            gy = img[r-1][c] - img[r][c-1];
        end else begin
            k = (md == 2) ? 2 : 1;
            gx = (img[r-2][c] + k*img[r-1][c] + img[r][c])
               - (img[r-2][c-2] + k*img[r-1][c-2] + img[r][c-2]);
            gy = (img[r][c-2] + k*img[r][c-1] + img[r][c])
               - (img[r-2][c-2] + k*img[r-2][c-1] + img[r-2][c]);
        end
        return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    endfunction

    // One cycle: check the output due now, then drive and model a new input.
    task automatic step(bit v, int pix, bit fs, int md, int thr, string tag);
        bit eb, brd;
        @(negedge clk);
        chk("R2 valid", out_valid, hv[2]);
        if (hv[2]) chk(ht[2], out_edge, he[2]);
        hv[2] = hv[1]; he[2] = he[1]; ht[2] = ht[1];
        hv[1] = hv[0]; he[1] = he[0]; ht[1] = ht[0];
        hv[0] = v; he[0] = 0; ht[0] = tag;
        if (fs) pend = 1;
        if (v) begin
            if (pend) begin
                mr = 0; mc = 0; ms = md; mt = thr; pend = 0;
            end
            img[mr][mc] = pix;
            brd = (ms == 0) ? (mr < 1 || mc < 1) : (mr < 2 || mc < 2);
            if (brd) begin
                eb = 0;
                ht[0] = "R7 border";
            end else begin
                eb = (mag_of(mr, mc, ms == 3 ? 1 : ms) > mt);
            end
            he[0] = eb;
            if (mc == LW-1) begin
                mc = 0;
                if (mr == RW-1) begin mr = 0; pend = 1; end
                else mr++;
            end else mc++;
        end
        in_valid = v; in_pix = pix[7:0]; frame_start = fs;
        op_sel = md[1:0]; edge_thr = thr[10:0];
    endtask

    // Whole frame with random stalls; chg scrambles settings after capture.
    task automatic frame(int md, int thr, int pat, bit fs, bit chg, string tag, int npix);
        int m, t;
        for (int i = 0; i < npix; i++) begin
            while ($urandom % 4 == 0) begin
                m = chg ? $urandom % 4 : md;
                t = chg ? $urandom % 2048 : thr;
                step(0, 0, 0, m, t, tag);
            end
            m = (chg && i > 0) ? $urandom % 4 : md;
            t = (chg && i > 0) ? $urandom % 2048 : thr;
            step(1, pixval(pat, i / LW, i % LW), fs && i == 0, m, t, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; frame_start = 0; in_valid = 0; in_pix = 0; op_sel = 0; edge_thr = 0;
        for (int i = 0; i < 3; i++) begin hv[i] = 0; he[i] = 0; ht[i] = "R2"; end
        repeat (4) @(negedge clk);
        chk("R1 reset valid", out_valid, 1'b0);
        chk("R1 reset edge", out_edge, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", out_valid, 1'b0);
        frame(0, 60, 0, 0, 0, "R3 diag", LW*RW);
        frame(1, 200, 0, 1, 0, "R4 unif", LW*RW);
        frame(3, 200, 0, 1, 0, "R4 spare", LW*RW);
        frame(2, 400, 0, 1, 0, "R5 cwt", LW*RW);
        frame(2, 1020, 1, 1, 0, "R6 thr equal", LW*RW);
        frame(2, 1019, 1, 1, 0, "R6 thr below", LW*RW);
        frame(0, 254, 2, 1, 0, "R6 diag max", LW*RW);
        frame(1, 500, 3, 1, 0, "R10 row step", LW*RW);
        frame(2, 300, 0, 1, 1, "R8 cfg change", LW*RW);
        frame(1, 100, 0, 0, 0, "R9 auto wrap", LW*RW);
        frame(0, 30, 0, 1, 0, "R9 abort", LW*RW/2);
        step(0, 0, 1, 2, 150, "R9 pulse");
        frame(2, 150, 0, 0, 0, "R9 restart", LW*RW);
        frame(1, 0, 4, 1, 0, "R6 flat", LW*RW);
        for (int f = 0; f < 16; f++)
            frame($urandom % 4, $urandom % 900, $urandom % 4, $urandom % 2, 0, "R2 random", LW*RW);
        repeat (5) step(0, 0, 0, 0, 0, "R2 drain");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule